// File: doc/BRIEF.md
# GPIO Bank with Edge-Triggered Interrupts

This block is a 32-pin general-purpose I/O bank behind a small register bus. Software uses it to choose the direction of each pin, drive output levels, read back the pad levels and raise interrupts on pin edges. Output levels and edge enables are normally changed through paired "set" and "clear" registers. A write to one of these changes only the bits written as one, so a single write can update one pin without a read-modify-write.

Every pad input passes through a two-stage synchronizer. Edges are found by comparing each synchronized value with its value one cycle earlier. An edge whose direction is enabled for that pin is latched into a status register, which software clears by writing ones. The status bits are split into two halves of 16 pins. Each half drives one registered interrupt line, and a per-line enable bit gates it.

The bus has no wait states. A write is captured on the rising clock edge while `bus_sel` and `bus_wr` are high. Read data is combinational from `bus_addr` while `bus_sel` is high and `bus_wr` is low, and is zero at all other times.

Top module: `gpio_edge_bank`

## Requirements
- R1: After reset, all direction bits read 1, so `pin_oe` is all zero. The following also read zero: the output latch, both edge-enable sets, the status register, the line enables and `irq_bank`.
- R2: The direction register is at offset 0x00 and is read/write. A bit of 1 makes the pin an input and a bit of 0 makes it an output. `pin_oe` is the inverse of this register from the cycle after the write.
- R3: A write to offset 0x0C sets the latch bits written as one, and a write to offset 0x10 clears them. Bits written as zero keep their value. Offset 0x04 reads the latch and loads it whole on a write, and 0x0C and 0x10 also read it. `pin_out` follows the latch from the cycle after the write.
- R4: Offset 0x14 is read-only and returns the synchronized pad level of every pin, whatever the pin's direction. A pad change becomes visible only after the second rising edge that follows it.
- R5: Rising-edge enables are set by a one-mask write to 0x18 and cleared by a one-mask write to 0x1C; both offsets read the rising enables. Falling-edge enables use 0x20 (set) and 0x24 (clear), and both offsets read the falling enables.
- R6: A synchronized 0-to-1 change on a pin with its rising enable set, or a 1-to-0 change with its falling enable set, sets that pin's bit in the status register at 0x28. The bit is readable after the third rising edge that follows the pad change. Edges in a direction that is not enabled leave the status register unchanged.
- R7: Writing to 0x28 clears the status bits written as one. Status bits written as zero are unchanged.
- R8: When a new edge and a clearing write hit the same status bit in the same cycle, the bit stays set.
- R9: The line enables are at offset 0x08, in bits 1:0, and are read/write. `irq_bank[0]` is the OR of status bits 15:0 gated by enable bit 0, and `irq_bank[1]` is the OR of bits 31:16 gated by enable bit 1. Each line is registered, so it changes one cycle after the status bit or enable bit it depends on.
- R10: Reads of unmapped offsets return zero. Writes to unmapped offsets change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bank clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 6 | Byte offset of the register |
| bus_wdata | input | 32 | Write data / one-mask |
| bus_rdata | output | 32 | Combinational read data |
| pin_in | input | 32 | Pad input levels (asynchronous) |
| pin_out | output | 32 | Output latch driven to the pads |
| pin_oe | output | 32 | Pad output enable, 1 = driven |
| irq_bank | output | 2 | Registered interrupt lines, one per 16-pin half |

## Verification
Register writes take effect on the capturing edge, so the bench reads them back at the next falling edge. A pad change is sampled two falling edges later for the input-data view, three for the status bit, and four for an interrupt line when its enable is already set. After an enable write, the line is sampled two falling edges later. The check that an edge wins over a clear places the clearing write on the same rising edge as the detected edge, two falling edges after the pad change. The early samples (input view after one edge, status after two, line right after an enable write) are also checked, so that a result arriving one cycle early is caught.

// File: rtl/gpio_pkg.sv
`timescale 1ns / 100ps
package gpio_pkg;

    localparam int unsigned GPIO_ADDR_W = 6;

    // Byte offsets of the bank registers
    typedef enum logic [GPIO_ADDR_W-1:0] {
        REG_DIR      = 6'h00,
        REG_OUT      = 6'h04,
        REG_LINE_EN  = 6'h08,
        REG_SET_DATA = 6'h0C,
        REG_CLR_DATA = 6'h10,
        REG_IN       = 6'h14,
        REG_SET_RISE = 6'h18,
        REG_CLR_RISE = 6'h1C,
        REG_SET_FALL = 6'h20,
        REG_CLR_FALL = 6'h24,
        REG_STATUS   = 6'h28
    } reg_addr_e;

    // One write strobe per writable register
    typedef struct packed {
        logic dir;
        logic out_load;
        logic line_en;
        logic set_data;
        logic clr_data;
        logic set_rise;
        logic clr_rise;
        logic set_fall;
        logic clr_fall;
        logic stat_clr;
    } wr_strobe_t;

endpackage

// File: rtl/gpio_bus_decode.sv
`timescale 1ns / 100ps
module gpio_bus_decode
    import gpio_pkg::*;
#(
    parameter int unsigned ADDR_W = GPIO_ADDR_W
) (
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    output wr_strobe_t        strobe
);

    always_comb begin
        strobe = '0;
        if (bus_sel && bus_wr) begin
            case (bus_addr)
                REG_DIR:      strobe.dir      = 1'b1;
                REG_OUT:      strobe.out_load = 1'b1;
                REG_LINE_EN:  strobe.line_en  = 1'b1;
                REG_SET_DATA: strobe.set_data = 1'b1;
                REG_CLR_DATA: strobe.clr_data = 1'b1;
                REG_SET_RISE: strobe.set_rise = 1'b1;
                REG_CLR_RISE: strobe.clr_rise = 1'b1;
                REG_SET_FALL: strobe.set_fall = 1'b1;
                REG_CLR_FALL: strobe.clr_fall = 1'b1;
                REG_STATUS:   strobe.stat_clr = 1'b1;
                default:      strobe          = '0;
            endcase
        end
    end

endmodule

// File: rtl/gpio_ctrl_regs.sv
`timescale 1ns / 100ps
module gpio_ctrl_regs
    import gpio_pkg::*;
#(
    parameter int unsigned NUM_PINS = 32,
    parameter int unsigned NUM_IRQ  = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  wr_strobe_t          strobe,
    input  logic [NUM_PINS-1:0] wdata,
    output logic [NUM_PINS-1:0] dir_q,
    output logic [NUM_PINS-1:0] out_q,
    output logic [NUM_PINS-1:0] rise_en_q,
    output logic [NUM_PINS-1:0] fall_en_q,
    output logic [NUM_IRQ-1:0]  line_en_q
);

    // Direction: 1 = input; reset leaves every pin undriven
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dir_q <= '1;
        end else if (strobe.dir) begin
            dir_q <= wdata;
        end
    end

    // Output latch: whole load, or one-mask set / clear
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= '0;
        end else if (strobe.out_load) begin
            out_q <= wdata;
        end else if (strobe.set_data) begin
            out_q <= out_q | wdata;
        end else if (strobe.clr_data) begin
            out_q <= out_q & ~wdata;
        end
    end

    // Edge enables, each changed only through its set / clear pair
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rise_en_q <= '0;
            fall_en_q <= '0;
        end else begin
            if (strobe.set_rise) begin
                rise_en_q <= rise_en_q | wdata;
            end else if (strobe.clr_rise) begin
                rise_en_q <= rise_en_q & ~wdata;
            end
            if (strobe.set_fall) begin
                fall_en_q <= fall_en_q | wdata;
            end else if (strobe.clr_fall) begin
                fall_en_q <= fall_en_q & ~wdata;
            end
        end
    end

    // Per-line interrupt enables
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            line_en_q <= '0;
        end else if (strobe.line_en) begin
            line_en_q <= wdata[NUM_IRQ-1:0];
        end
    end

endmodule

// File: rtl/gpio_in_sync.sv
`timescale 1ns / 100ps
module gpio_in_sync #(
    parameter int unsigned NUM_PINS    = 32,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PINS-1:0] pin_in,
    output logic [NUM_PINS-1:0] sync_val,
    output logic [NUM_PINS-1:0] prev_val
);

    localparam int unsigned LAST = SYNC_STAGES - 1;

    logic [NUM_PINS-1:0] stage_q [SYNC_STAGES];

    for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage_q[s] <= '0;
                else        stage_q[s] <= pin_in;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage_q[s] <= '0;
                else        stage_q[s] <= stage_q[s-1];
            end
        end
    end

    // One more register holds last cycle's synchronized value for edge compare
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_val <= '0;
        else        prev_val <= stage_q[LAST];
    end

    assign sync_val = stage_q[LAST];

endmodule

// File: rtl/gpio_edge_irq.sv
`timescale 1ns / 100ps
module gpio_edge_irq #(
    parameter int unsigned NUM_PINS     = 32,
    parameter int unsigned PINS_PER_IRQ = 16,
    parameter int unsigned NUM_IRQ      = NUM_PINS / PINS_PER_IRQ
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PINS-1:0] sync_val,
    input  logic [NUM_PINS-1:0] prev_val,
    input  logic [NUM_PINS-1:0] rise_en,
    input  logic [NUM_PINS-1:0] fall_en,
    input  logic                stat_clr,
    input  logic [NUM_PINS-1:0] wdata,
    input  logic [NUM_IRQ-1:0]  line_en,
    output logic [NUM_PINS-1:0] edge_hit,
    output logic [NUM_PINS-1:0] status_q,
    output logic [NUM_IRQ-1:0]  irq_q
);

    logic [NUM_PINS-1:0] clr_mask;

    assign edge_hit = (sync_val & ~prev_val & rise_en)
                    | (~sync_val & prev_val & fall_en);
    assign clr_mask = stat_clr ? wdata : '0;

    // A fresh edge overrides a clear of the same bit
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) status_q <= '0;
        else        status_q <= (status_q & ~clr_mask) | edge_hit;
    end

    for (genvar b = 0; b < NUM_IRQ; b++) begin : g_line
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) irq_q[b] <= 1'b0;
            else        irq_q[b] <= line_en[b] & (|status_q[b*PINS_PER_IRQ +: PINS_PER_IRQ]);
        end
    end

endmodule

// File: rtl/gpio_edge_bank.sv
`timescale 1ns / 100ps
module gpio_edge_bank
    import gpio_pkg::*;
#(
    parameter int unsigned NUM_PINS     = 32,
    parameter int unsigned PINS_PER_IRQ = 16,
    parameter int unsigned SYNC_STAGES  = 2,
    parameter int unsigned ADDR_W       = GPIO_ADDR_W
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                bus_sel,
    input  logic                                bus_wr,
    input  logic [ADDR_W-1:0]                   bus_addr,
    input  logic [NUM_PINS-1:0]                 bus_wdata,
    output logic [NUM_PINS-1:0]                 bus_rdata,
    input  logic [NUM_PINS-1:0]                 pin_in,
    output logic [NUM_PINS-1:0]                 pin_out,
    output logic [NUM_PINS-1:0]                 pin_oe,
    output logic [NUM_PINS/PINS_PER_IRQ-1:0]    irq_bank
);

    localparam int unsigned NUM_IRQ = NUM_PINS / PINS_PER_IRQ;

    wr_strobe_t          strobe;
    logic [NUM_PINS-1:0] dir_q;
    logic [NUM_PINS-1:0] out_q;
    logic [NUM_PINS-1:0] rise_en_q;
    logic [NUM_PINS-1:0] fall_en_q;
    logic [NUM_IRQ-1:0]  line_en_q;
    logic [NUM_PINS-1:0] sync_val;
    logic [NUM_PINS-1:0] prev_val;
    logic [NUM_PINS-1:0] edge_hit;
    logic [NUM_PINS-1:0] stat_q;
    logic [NUM_PINS-1:0] rd_mux;

    gpio_bus_decode #(.ADDR_W(ADDR_W)) u_decode (
        .bus_sel  (bus_sel),
        .bus_wr   (bus_wr),
        .bus_addr (bus_addr),
        .strobe   (strobe)
    );

    gpio_ctrl_regs #(.NUM_PINS(NUM_PINS), .NUM_IRQ(NUM_IRQ)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .strobe    (strobe),
        .wdata     (bus_wdata),
        .dir_q     (dir_q),
        .out_q     (out_q),
        .rise_en_q (rise_en_q),
        .fall_en_q (fall_en_q),
        .line_en_q (line_en_q)
    );

    gpio_in_sync #(.NUM_PINS(NUM_PINS), .SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .pin_in   (pin_in),
        .sync_val (sync_val),
        .prev_val (prev_val)
    );

    gpio_edge_irq #(
        .NUM_PINS     (NUM_PINS),
        .PINS_PER_IRQ (PINS_PER_IRQ),
        .NUM_IRQ      (NUM_IRQ)
    ) u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .sync_val (sync_val),
        .prev_val (prev_val),
        .rise_en  (rise_en_q),
        .fall_en  (fall_en_q),
        .stat_clr (strobe.stat_clr),
        .wdata    (bus_wdata),
        .line_en  (line_en_q),
        .edge_hit (edge_hit),
        .status_q (stat_q),
        .irq_q    (irq_bank)
    );

    always_comb begin
        rd_mux = '0;
        case (bus_addr)
            REG_DIR:      rd_mux = dir_q;
            REG_OUT:      rd_mux = out_q;
            REG_LINE_EN:  rd_mux = {{(NUM_PINS-NUM_IRQ){1'b0}}, line_en_q};
            REG_SET_DATA: rd_mux = out_q;
            REG_CLR_DATA: rd_mux = out_q;
            REG_IN:       rd_mux = sync_val;
            REG_SET_RISE: rd_mux = rise_en_q;
            REG_CLR_RISE: rd_mux = rise_en_q;
            REG_SET_FALL: rd_mux = fall_en_q;
            REG_CLR_FALL: rd_mux = fall_en_q;
            REG_STATUS:   rd_mux = stat_q;
            default:      rd_mux = '0;
        endcase
    end

    assign bus_rdata = (bus_sel && !bus_wr) ? rd_mux : '0;
    assign pin_out   = out_q;
    assign pin_oe    = ~dir_q;

endmodule

// File: rtl/gpio_edge_bank_checker.sv
`timescale 1ns / 100ps
module gpio_edge_bank_checker
    import gpio_pkg::*;
#(
    parameter int unsigned NUM_PINS     = 32,
    parameter int unsigned PINS_PER_IRQ = 16,
    parameter int unsigned ADDR_W       = GPIO_ADDR_W,
    parameter int unsigned NUM_IRQ      = NUM_PINS / PINS_PER_IRQ
) (
    input logic                clk,
    input logic                rst_n,
    input logic                bus_sel,
    input logic                bus_wr,
    input logic [ADDR_W-1:0]   bus_addr,
    input logic [NUM_PINS-1:0] bus_wdata,
    input logic [NUM_PINS-1:0] pin_out,
    input logic [NUM_PINS-1:0] pin_oe,
    input logic [NUM_IRQ-1:0]  irq_bank,
    input logic [NUM_PINS-1:0] status,
    input logic [NUM_IRQ-1:0]  line_en,
    input logic [NUM_PINS-1:0] edge_vec
);

    logic wr_dir, wr_set, wr_clr, wr_stat;
    assign wr_dir  = bus_sel && bus_wr && (bus_addr == REG_DIR);
    assign wr_set  = bus_sel && bus_wr && (bus_addr == REG_SET_DATA);
    assign wr_clr  = bus_sel && bus_wr && (bus_addr == REG_CLR_DATA);
    assign wr_stat = bus_sel && bus_wr && (bus_addr == REG_STATUS);

    a_r2_dir_drives_oe: assert property (@(posedge clk) disable iff (!rst_n)
        wr_dir |=> (pin_oe == ~$past(bus_wdata)));

    a_r3_set_drives_high: assert property (@(posedge clk) disable iff (!rst_n)
        wr_set |=> ((pin_out & $past(bus_wdata)) == $past(bus_wdata)));

    a_r3_clr_drives_low: assert property (@(posedge clk) disable iff (!rst_n)
        wr_clr |=> ((pin_out & $past(bus_wdata)) == '0));

    a_r7_w1c_clears: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stat |=> ((status & $past(bus_wdata) & ~$past(edge_vec)) == '0));

    a_r8_edge_sets_status: assert property (@(posedge clk) disable iff (!rst_n)
        (|edge_vec) |=> ((status & $past(edge_vec)) == $past(edge_vec)));

    a_r9_line0_gated: assert property (@(posedge clk) disable iff (!rst_n)
        !line_en[0] |=> !irq_bank[0]);

    a_r9_line1_gated: assert property (@(posedge clk) disable iff (!rst_n)
        !line_en[1] |=> !irq_bank[1]);

    a_r9_line0_needs_status: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_bank[0]) |-> $past(|status[PINS_PER_IRQ-1:0]));

endmodule

bind gpio_edge_bank gpio_edge_bank_checker #(
    .NUM_PINS     (NUM_PINS),
    .PINS_PER_IRQ (PINS_PER_IRQ),
    .ADDR_W       (ADDR_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .pin_out   (pin_out),
    .pin_oe    (pin_oe),
    .irq_bank  (irq_bank),
    .status    (stat_q),
    .line_en   (line_en_q),
    .edge_vec  (edge_hit)
);

// File: tb/gpio_edge_bank_bench.sv
`timescale 1ns / 100ps
module gpio_edge_bank_bench;

    localparam logic [5:0] A_DIR = 6'h00, A_OUT = 6'h04, A_LEN = 6'h08,
                           A_SD  = 6'h0C, A_CD  = 6'h10, A_IN  = 6'h14,
                           A_SR  = 6'h18, A_CR  = 6'h1C, A_SF  = 6'h20,
                           A_CF  = 6'h24, A_ST  = 6'h28, A_NONE = 6'h3C;

    // {req[3:0], write addr[5:0], write data[31:0], read addr[5:0], expected[31:0]}
    localparam int NV = 17;
    localparam logic [79:0] VEC [NV] = '{
        {4'd2,  A_DIR,  32'h0000FFFF, A_DIR, 32'h0000FFFF},  // R2
        {4'd3,  A_SD,   32'h000000F0, A_OUT, 32'h000000F0},  // R3
        {4'd3,  A_SD,   32'h0F000000, A_OUT, 32'h0F0000F0},  // R3
        {4'd3,  A_CD,   32'h00000030, A_OUT, 32'h0F0000C0},  // R3
        {4'd3,  A_CD,   32'h00000000, A_CD,  32'h0F0000C0},  // R3 zeros kept
        {4'd3,  A_OUT,  32'h12345678, A_SD,  32'h12345678},  // R3 whole load
        {4'd5,  A_SR,   32'h00010001, A_SR,  32'h00010001},  // R5
        {4'd5,  A_SR,   32'h00000100, A_CR,  32'h00010101},  // R5
        {4'd5,  A_CR,   32'h00010000, A_SR,  32'h00000101},  // R5
        {4'd5,  A_SF,   32'hFFFF0000, A_SF,  32'hFFFF0000},  // R5
        {4'd5,  A_CF,   32'h0FFF0000, A_CF,  32'hF0000000},  // R5
        {4'd9,  A_LEN,  32'hFFFFFFFF, A_LEN, 32'h00000003},  // R9
        {4'd10, A_NONE, 32'hFFFFFFFF, A_NONE,32'h00000000},  // R10
        {4'd5,  A_CF,   32'hFFFFFFFF, A_SF,  32'h00000000},  // R5
        {4'd5,  A_CR,   32'hFFFFFFFF, A_SR,  32'h00000000},  // R5
        {4'd9,  A_LEN,  32'h00000000, A_LEN, 32'h00000000},  // R9
        {4'd7,  A_ST,   32'hFFFFFFFF, A_ST,  32'h00000000}   // R7
    };

    logic        clk = 1'b0;
    logic        rst_n;
    logic        bus_sel, bus_wr;
    logic [5:0]  bus_addr;
    logic [31:0] bus_wdata, bus_rdata, pin_in, pin_out, pin_oe;
    logic [1:0]  irq_bank;
    int          n_checks = 0;
    int          n_err = 0;
    logic [31:0] rd;

    always #2.5 clk = ~clk;  // 200 MHz

    gpio_edge_bank u_gpio_edge_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pin_in    (pin_in),
        .pin_out   (pin_out),
        .pin_oe    (pin_oe),
        .irq_bank  (irq_bank)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Called at a falling edge; captured at the next rising edge; returns at the following falling edge
    task automatic bus_write(input logic [5:0] a, input logic [31:0] d);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0; bus_sel = 1'b0; bus_wdata = '0;
    endtask

    task automatic bus_read(input logic [5:0] a, output logic [31:0] d);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1;
        d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", n_checks, n_err);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++; n_err++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        rst_n = 1'b0; bus_sel = 1'b0; bus_wr = 1'b0; bus_addr = '0;
        bus_wdata = '0; pin_in = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1 pin_oe", pin_oe, 32'h0);
        check("R1 pin_out", pin_out, 32'h0);
        check("R1 irq", {30'h0, irq_bank}, 32'h0);
        bus_read(A_DIR, rd); check("R1 dir", rd, 32'hFFFFFFFF);
        bus_read(A_SR, rd);  check("R1 rise", rd, 32'h0);
        bus_read(A_SF, rd);  check("R1 fall", rd, 32'h0);
        bus_read(A_ST, rd);  check("R1 status", rd, 32'h0);
        bus_read(A_LEN, rd); check("R1 line_en", rd, 32'h0);

        // Register table
        for (int i = 0; i < NV; i++) begin
            bus_write(VEC[i][75:70], VEC[i][69:38]);
            bus_read(VEC[i][37:32], rd);
            check($sformatf("R%0d vec%0d", VEC[i][79:76], i), rd, VEC[i][31:0]);
        end

        // R2 / R3 pins
        check("R2 pin_oe", pin_oe, 32'hFFFF0000);
        check("R3 pin_out", pin_out, 32'h12345678);

        // R4 synchronizer latency, pins as outputs
        bus_write(A_DIR, 32'h0);
        pin_in = 32'hA5A53C3C;
        bus_read(A_IN, rd); check("R4 before edge", rd, 32'h0);
        @(negedge clk);
        bus_read(A_IN, rd); check("R4 after one edge", rd, 32'h0);
        @(negedge clk);
        bus_read(A_IN, rd); check("R4 after two edges", rd, 32'hA5A53C3C);
        pin_in = 32'h0;
        repeat (3) @(negedge clk);
        bus_read(A_ST, rd); check("R6 disabled edges ignored", rd, 32'h0);

        // R6 / R9 detection and line gating
        bus_write(A_DIR, 32'hFFFFFFFF);
        bus_write(A_SR, 32'h00000008);
        bus_write(A_SF, 32'h00100000);
        pin_in = 32'h00100018;
        repeat (2) @(negedge clk);
        bus_read(A_ST, rd); check("R6 not yet", rd, 32'h0);
        @(negedge clk);
        bus_read(A_ST, rd); check("R6 rise latched", rd, 32'h00000008);
        @(negedge clk);
        check("R9 line disabled", {30'h0, irq_bank}, 32'h0);
        bus_write(A_LEN, 32'h1);
        check("R9 registered line", {30'h0, irq_bank}, 32'h0);
        @(negedge clk);
        check("R9 line0 up", {30'h0, irq_bank}, 32'h1);
        pin_in = 32'h00000018;
        repeat (3) @(negedge clk);
        bus_read(A_ST, rd); check("R6 fall latched", rd, 32'h00100008);
        check("R9 line1 gated", {30'h0, irq_bank}, 32'h1);
        bus_write(A_LEN, 32'h3);
        @(negedge clk);
        check("R9 both lines", {30'h0, irq_bank}, 32'h3);

        // R7 write-one-to-clear
        bus_write(A_ST, 32'h00000008);
        bus_read(A_ST, rd); check("R7 clear one", rd, 32'h00100000);
        @(negedge clk);
        check("R9 line0 drops", {30'h0, irq_bank}, 32'h2);
        bus_write(A_ST, 32'h0);
        bus_read(A_ST, rd); check("R7 zeros kept", rd, 32'h00100000);

        // R8 edge wins over a same-cycle clear
        bus_write(A_SR, 32'h00000020);
        bus_write(A_SF, 32'h00000020);
        pin_in = 32'h00000038;
        repeat (3) @(negedge clk);
        bus_read(A_ST, rd); check("R8 setup", rd, 32'h00100020);
        pin_in = 32'h00000018;
        repeat (2) @(negedge clk);
        bus_write(A_ST, 32'h00000020);
        bus_read(A_ST, rd); check("R8 edge wins", rd, 32'h00100020);
        bus_write(A_ST, 32'h00100020);
        bus_read(A_ST, rd); check("R7 all cleared", rd, 32'h0);
        @(negedge clk);
        check("R9 lines idle", {30'h0, irq_bank}, 32'h0);

        finish_run();
    end

endmodule